// File: doc/BRIEF.md
# Audio sample-rate clock generator

This block produces the family of audio-rate clocks that a converter or serial audio port needs. The block is built around a master clock that runs at either 384 or 512 times the sample rate. The master is taken from an external reference clock or from a free-running oscillator input. All slower clocks are produced by a chain of counters. That chain runs in the master clock domain, and every derived clock leaves the block straight from a flip-flop.

Three static select pins set the configuration. The first picks the master source. The second picks the first divide stage, either 3 or 4, which turns the master into a 128fs clock. The third picks the origin of the bit and word clocks. They are either divided locally from the 128fs clock, or slaved to an incoming bit clock and word clock. In slaved mode those inputs are first synchronised into the master domain. The 32fs and 2fs outputs are then divided from the incoming bit clock, and they realign to each rising edge of the incoming word clock. The select pins are expected to change only while reset is asserted.

Top module: `fsclk_gen`

## Requirements
- R1: `mclk_o` follows `clk_ref_i` when `src_sel_i` is 0 and follows `clk_osc_i` when `src_sel_i` is 1.
- R2: While `rst_n` is low, every derived output (`half_o`, `fs128_o`, `bit_o`, `bit_half_o`, `word2_o`, `word_o`) is low. In local mode, `fs128_o`, `bit_o`, `bit_half_o`, `word2_o` and `word_o` are still low after the (D-1)th master rising edge following release, and all rise together on the Dth edge, where D is the first-stage divide ratio.
- R3: `half_o` has a period of 2 master cycles.
- R4: `fs128_o` has a period of D master cycles, with D = 3 when `ratio_sel_i` is 0 and D = 4 when it is 1. It is high for 1 master cycle when D = 3 and for 2 master cycles when D = 4.
- R5: In local mode (`ext_sync_i` = 0), `bit_o` has twice the period of `fs128_o` and rises only together with it.
- R6: `bit_half_o` has twice the period of `bit_o`.
- R7: `word2_o` has 32 times the period of `bit_o`.
- R8: In local mode, `word_o` has 64 times the period of `bit_o` and rises only together with `word2_o`.
- R9: In slaved mode (`ext_sync_i` = 1), `bit_o` reproduces `bclk_i` and `word_o` reproduces `lrck_i`, with the same periods.
- R10: In slaved mode, `bit_half_o` and `word2_o` are divided from `bclk_i`. On each rising edge of `lrck_i` the count restarts, so that `word2_o` rises on the first rising edge of `bclk_i` after the `lrck_i` rising edge. When `lrck_i` changes on a falling edge of `bclk_i`, that is half a bit period later at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | External reference master clock |
| clk_osc_i | input | 1 | Free-running oscillator master clock |
| rst_n | input | 1 | Active-low asynchronous reset of all counters |
| src_sel_i | input | 1 | Master source: 0 reference, 1 oscillator |
| ratio_sel_i | input | 1 | First divide stage: 0 divide by 3, 1 divide by 4 |
| ext_sync_i | input | 1 | 0 local bit/word clocks, 1 slaved to inputs |
| bclk_i | input | 1 | Incoming 64fs bit clock (slaved mode) |
| lrck_i | input | 1 | Incoming word clock (slaved mode) |
| mclk_o | output | 1 | Selected master clock |
| half_o | output | 1 | Master divided by 2 |
| fs128_o | output | 1 | 128fs clock |
| bit_o | output | 1 | 64fs bit clock |
| bit_half_o | output | 1 | 32fs clock |
| word2_o | output | 1 | 2fs word clock |
| word_o | output | 1 | 1fs left/right word clock |

## Verification
Several properties hold on every master cycle and are covered by the embedded assertions. The first-stage counter stays inside its range. All derived outputs are quiet during reset. In local mode, each slower clock rises only on a cycle where the next faster clock also rises, which shows the divider chain stays phase-locked. The periods and the high time of the divide-by-3 or divide-by-4 stage are only visible over many cycles, so the bench scenarios measure them. The scenarios also cover the exact edge on which the outputs first rise after reset, the switch to the oscillator source, and the half-bit-period offset of the realigned 2fs clock in slaved mode.

// File: rtl/fsclk_pkg.sv
package fsclk_pkg;
  localparam int unsigned DIV_LO = 3;
  localparam int unsigned DIV_HI = 4;
  localparam int unsigned DCNT_W = $clog2(DIV_HI);

  // last count value of the first divide stage
  function automatic logic [DCNT_W-1:0] div_last(input logic ratio_sel);
    return ratio_sel ? DCNT_W'(DIV_HI - 1) : DCNT_W'(DIV_LO - 1);
  endfunction

  // count value at which the 128fs high window closes (1 or 2 cycles high)
  function automatic logic [DCNT_W-1:0] high_last(input logic ratio_sel);
    return ratio_sel ? DCNT_W'(1) : DCNT_W'(0);
  endfunction
endpackage

// File: rtl/fsclk_src_mux.sv
module fsclk_src_mux (
  input  logic ref_i,
  input  logic osc_i,
  input  logic sel_i,
  output logic mck_o
);
  // static select only; switching happens under reset
  assign mck_o = sel_i ? osc_i : ref_i;
endmodule

// File: rtl/fsclk_edge_sync.sv
module fsclk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[STAGES-1];

  assign lvl_o  = sh[STAGES-1];
  assign rise_o = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/fsclk_master_div.sv
module fsclk_master_div
  import fsclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ratio_sel_i,
  output logic half_o,
  output logic fs128_o,
  output logic bit_o,
  output logic bit_tick_o
);
  logic [DCNT_W-1:0] dcnt;
  logic              wrap;

  assign wrap       = (dcnt == div_last(ratio_sel_i));
  assign bit_tick_o = wrap & ~bit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt    <= '0;
      half_o  <= 1'b0;
      fs128_o <= 1'b0;
      bit_o   <= 1'b0;
    end else begin
      half_o <= ~half_o;
      dcnt   <= wrap ? '0 : dcnt + 1'b1;
      if (wrap)                                fs128_o <= 1'b1;
      else if (dcnt == high_last(ratio_sel_i)) fs128_o <= 1'b0;
      if (wrap) bit_o <= ~bit_o;
    end
  end

  // R4: first-stage counter never leaves its range while the ratio is static
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(ratio_sel_i) |-> (dcnt <= div_last(ratio_sel_i)));
endmodule

// File: rtl/fsclk_frame_div.sv
module fsclk_frame_div #(
  parameter int unsigned WORD_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel_i,
  input  logic bit_tick_i,
  input  logic lr_lvl_i,
  input  logic lr_rise_i,
  output logic fs32_o,
  output logic w2_o,
  output logic word_o
);
  localparam int unsigned CW = $clog2(WORD_BITS);

  logic [CW-1:0] pcnt;
  logic [CW-1:0] base;
  logic          realign;

  assign realign = ext_sel_i & lr_rise_i;
  assign base    = realign ? '0 : pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      fs32_o <= 1'b0;
      w2_o   <= 1'b0;
      word_o <= 1'b0;
    end else begin
      if (bit_tick_i) begin
        pcnt   <= base + 1'b1;
        fs32_o <= ~base[0];
        w2_o   <= ~base[CW-2];
        if (!ext_sel_i) word_o <= ~base[CW-1];
      end else if (realign) begin
        pcnt <= '0;
      end
      if (ext_sel_i) word_o <= lr_lvl_i;
    end
  end
endmodule

// File: rtl/fsclk_gen.sv
module fsclk_gen #(
  parameter int unsigned WORD_BITS   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_ref_i,
  input  logic clk_osc_i,
  input  logic rst_n,
  input  logic src_sel_i,
  input  logic ratio_sel_i,
  input  logic ext_sync_i,
  input  logic bclk_i,
  input  logic lrck_i,
  output logic mclk_o,
  output logic half_o,
  output logic fs128_o,
  output logic bit_o,
  output logic bit_half_o,
  output logic word2_o,
  output logic word_o
);
  logic mck;
  logic bit_loc, bit_tick_loc;
  logic bclk_lvl, bclk_rise, lr_lvl, lr_rise;
  logic bit_ext_q;
  logic bit_tick;

  fsclk_src_mux u_mux (
    .ref_i (clk_ref_i), .osc_i (clk_osc_i), .sel_i (src_sel_i), .mck_o (mck)
  );

  fsclk_master_div u_mdiv (
    .clk (mck), .rst_n (rst_n), .ratio_sel_i (ratio_sel_i),
    .half_o (half_o), .fs128_o (fs128_o), .bit_o (bit_loc), .bit_tick_o (bit_tick_loc)
  );

  fsclk_edge_sync #(.STAGES(SYNC_STAGES)) u_bsync (
    .clk (mck), .rst_n (rst_n), .d_i (bclk_i), .lvl_o (bclk_lvl), .rise_o (bclk_rise)
  );

  fsclk_edge_sync #(.STAGES(SYNC_STAGES)) u_lsync (
    .clk (mck), .rst_n (rst_n), .d_i (lrck_i), .lvl_o (lr_lvl), .rise_o (lr_rise)
  );

  always_ff @(posedge mck or negedge rst_n)
    if (!rst_n) bit_ext_q <= 1'b0;
    else        bit_ext_q <= bclk_lvl;

  assign bit_tick = ext_sync_i ? bclk_rise : bit_tick_loc;

  fsclk_frame_div #(.WORD_BITS(WORD_BITS)) u_fdiv (
    .clk (mck), .rst_n (rst_n), .ext_sel_i (ext_sync_i),
    .bit_tick_i (bit_tick), .lr_lvl_i (lr_lvl), .lr_rise_i (lr_rise),
    .fs32_o (bit_half_o), .w2_o (word2_o), .word_o (word_o)
  );

  assign mclk_o = mck;
  assign bit_o  = ext_sync_i ? bit_ext_q : bit_loc;

  // R2: derived outputs quiet during reset
  a_r2_reset_quiet: assert property (@(posedge mck)
    !rst_n |-> !(half_o | fs128_o | bit_o | bit_half_o | word2_o | word_o));

  // R5: local bit clock rises only with the 128fs clock
  a_r5_bit_with_f128: assert property (@(posedge mck) disable iff (!rst_n)
    (!ext_sync_i && $rose(bit_o)) |-> $rose(fs128_o));

  // R6: 32fs rises only with the bit clock (local mode)
  a_r6_half_with_bit: assert property (@(posedge mck) disable iff (!rst_n)
    (!ext_sync_i && $rose(bit_half_o)) |-> $rose(bit_o));

  // R7: 2fs rises only with the 32fs clock (local mode)
  a_r7_w2_with_half: assert property (@(posedge mck) disable iff (!rst_n)
    (!ext_sync_i && $rose(word2_o)) |-> $rose(bit_half_o));

  // R8: word clock rises only with the 2fs clock (local mode)
  a_r8_word_with_w2: assert property (@(posedge mck) disable iff (!rst_n)
    (!ext_sync_i && $rose(word_o)) |-> $rose(word2_o));
endmodule

// File: tb/fsclk_gen_tb.sv
`timescale 1ns/1ps
module fsclk_gen_tb;
  logic clk_ref = 1'b0;
  logic clk_osc = 1'b0;
  logic rst_n   = 1'b0;
  logic src_sel = 1'b0, ratio_sel = 1'b0, ext_sync = 1'b0;
  logic bclk = 1'b0, lrck = 1'b0;
  logic ext_run = 1'b0;
  logic mclk, half, fs128, bitc, bhalf, w2, word;
  int   errors = 0, checks = 0;
  int   mon_sel = 0;
  logic mon;

  always #4 clk_ref = ~clk_ref;   // 125 MHz
  always #5 clk_osc = ~clk_osc;   // 100 MHz

  fsclk_gen u_dut (
    .clk_ref_i (clk_ref), .clk_osc_i (clk_osc), .rst_n (rst_n),
    .src_sel_i (src_sel), .ratio_sel_i (ratio_sel), .ext_sync_i (ext_sync),
    .bclk_i (bclk), .lrck_i (lrck),
    .mclk_o (mclk), .half_o (half), .fs128_o (fs128), .bit_o (bitc),
    .bit_half_o (bhalf), .word2_o (w2), .word_o (word)
  );

  always_comb begin
    case (mon_sel)
      0: mon = mclk;
      1: mon = half;
      2: mon = fs128;
      3: mon = bitc;
      4: mon = bhalf;
      5: mon = w2;
      default: mon = word;
    endcase
  end

  // external bit clock: 64 ns period; word clock flips on bit-clock falling edges
  initial begin
    int div = 0, nb = 0;
    forever begin
      @(negedge clk_ref);
      if (ext_run) begin
        div++;
        if (div == 4) begin
          div  = 0;
          bclk = ~bclk;
          if (!bclk) begin
            nb++;
            if (nb == 32) begin nb = 0; lrck = ~lrck; end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas_period(input int sel, output int p);
    realtime t0;
    mon_sel = sel;
    #1;
    @(posedge mon); @(posedge mon); t0 = $realtime;
    @(posedge mon); p = int'($realtime - t0);
  endtask

  task automatic meas_high(input int sel, output int p);
    realtime t0;
    mon_sel = sel;
    #1;
    @(posedge mon); @(posedge mon); t0 = $realtime;
    @(negedge mon); p = int'($realtime - t0);
  endtask

  task automatic do_reset(input logic s, input logic r, input logic e);
    @(negedge clk_ref);
    rst_n = 1'b0; ext_run = 1'b0;
    src_sel = s; ratio_sel = r; ext_sync = e;
    repeat (3) @(negedge clk_ref);
  endtask

  // R2: quiet during reset, common first rising edge after release
  task automatic t_reset_align(input logic r);
    int d;
    d = r ? 4 : 3;
    do_reset(1'b0, r, 1'b0);
    chk("R2 reset outputs", int'({half, fs128, bitc, bhalf, w2, word}), 0);
    rst_n = 1'b1;
    for (int e = 1; e <= d; e++) begin
      @(posedge clk_ref); #2;
      if (e == d - 1) chk("R2 low before edge D", int'({fs128, bitc, bhalf, w2, word}), 0);
      if (e == d)     chk("R2 all rise on edge D", int'({fs128, bitc, bhalf, w2, word}), 31);
    end
  endtask

  // R3..R8 local dividers
  task automatic t_local(input logic r);
    int d, p;
    d = r ? 4 : 3;
    do_reset(1'b0, r, 1'b0);
    rst_n = 1'b1;
    meas_period(0, p); chk("R1 master from reference", p, 8);
    meas_period(1, p); chk("R3 half period", p, 16);
    meas_period(2, p); chk("R4 128fs period", p, 8 * d);
    meas_high(2, p);   chk("R4 128fs high time", p, r ? 16 : 8);
    meas_period(3, p); chk("R5 bit period", p, 16 * d);
    meas_period(4, p); chk("R6 32fs period", p, 32 * d);
    meas_period(5, p); chk("R7 2fs period", p, 512 * d);
    meas_period(6, p); chk("R8 word period", p, 1024 * d);
    meas_high(6, p);   chk("R8 word high time", p, 512 * d);
  endtask

  // R1 oscillator source
  task automatic t_osc;
    int p;
    do_reset(1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    meas_period(0, p); chk("R1 master from oscillator", p, 10);
    meas_period(1, p); chk("R3 half period on oscillator", p, 20);
    meas_period(2, p); chk("R4 128fs period on oscillator", p, 30);
  endtask

  // R9, R10 slaved mode
  task automatic t_slave;
    int p;
    realtime t0;
    do_reset(1'b0, 1'b0, 1'b1);
    rst_n = 1'b1;
    ext_run = 1'b1;
    meas_period(3, p); chk("R9 bit follows bclk", p, 64);
    meas_period(6, p); chk("R9 word follows lrck", p, 4096);
    meas_period(4, p); chk("R10 32fs from bclk", p, 128);
    meas_period(5, p); chk("R10 2fs from bclk", p, 2048);
    @(posedge word); t0 = $realtime;
    @(posedge w2);
    chk("R10 2fs realigned to word", int'($realtime - t0), 32);
    ext_run = 1'b0;
  endtask

  initial begin
    #400_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset_align(1'b0);
    t_reset_align(1'b1);
    t_local(1'b0);
    t_local(1'b1);
    t_osc;
    t_slave;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule